// File: doc/BRIEF.md
# SPI Burst Master Engine

This block is a single-lane SPI master that moves whole bursts of words between two on-chip FIFOs and a serial peripheral. Software loads outgoing words into a transmit FIFO, programs the clock divider, the word length, the idle spacing between words and a word count, then either pulses a start input for a transmit or full-duplex burst, or raises a start level for a receive-only burst. The engine pops one word per frame, shifts it out MSB first while shifting the incoming line in, and pushes each received word into a receive FIFO.

Two sticky event flags report progress: a transmit-end flag once the last word of a burst has been taken from the transmit FIFO, and a receive-end flag once the last received word has been stored. The busy output stays high until the serial line has actually gone quiet, so it clears after the transmit-end flag. Chip select, clock polarity and sampling edge are under direct control, and a FIFO flush input empties both queues.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset cs_n is 1, sck equals cfg_cpol, busy and irq are 0, raw_sts is all zero, and both FIFOs are empty.
- R2: While a word is shifting, consecutive sck transitions are cfg_prescale+1 clock cycles apart; whenever the engine is idle or between words, sck rests at cfg_cpol.
- R3: A word carries cfg_wlen bits (code 0 selects 32); it leaves on mosi most significant bit first, and the received word is right-aligned and zero-extended to 32 bits.
- R4: With cfg_cpha=0 miso is sampled on the first sck transition of each bit and mosi changes on the second; with cfg_cpha=1 mosi changes on the first and miso is sampled on the second, in all four polarity and phase combinations.
- R5: Between the last sck transition of one word and the first of the next there are 4*cfg_gap+10 idle cycles, one load cycle and one half period, i.e. 4*cfg_gap+12+cfg_prescale clock cycles.
- R6: A pulse on go with cfg_tx_en=1 starts a burst of {burst_len_hi,burst_len_lo} words taken from the transmit FIFO; received words are stored only when cfg_rx_en=1, so a transmit-only burst leaves the receive FIFO empty.
- R7: With cfg_rx_en=1 and cfg_tx_en=0, a rising edge of rx_only_start runs rx_only_cnt frames with mosi held at 0; dropping rx_only_start returns the engine to idle.
- R8: raw_sts bit 8 (transmit end) is set when the last word of a burst is taken from the transmit FIFO, while busy is still 1; busy falls only after the final sck transition of the burst.
- R9: raw_sts bit 9 (receive end) is set when the last received word of a burst is stored; it stays 0 in a transmit-only burst.
- R10: Writing 1 to a bit of int_clr clears the same raw_sts bit; if the setting event and the clear fall in the same cycle, the bit is set.
- R11: irq is 1 exactly when some raw_sts bit and the same int_en bit are both 1.
- R12: When both cfg_tx_en and cfg_rx_en are 0, an active burst stops and busy is 0 on the next cycle, and go has no effect.
- R13: cs_n follows cs_ctl_n with one clock cycle of delay.
- R14: While fifo_rst is 1 both FIFOs are emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_cpha | input | 1 | 0: sample on first transition, 1: sample on second |
| cfg_prescale | input | 8 | sck half period minus one, in clock cycles |
| cfg_wlen | input | 5 | Bits per word, 0 means 32 |
| cfg_gap | input | 6 | Inter-word spacing code |
| cfg_tx_en | input | 1 | Transmit mode bit |
| cfg_rx_en | input | 1 | Receive mode bit |
| burst_len_hi | input | 4 | Upper part of the burst word count |
| burst_len_lo | input | 16 | Lower part of the burst word count |
| go | input | 1 | Start pulse for transmit and full-duplex bursts |
| rx_only_cnt | input | 9 | Frame count for receive-only bursts |
| rx_only_start | input | 1 | Receive-only start level |
| cs_ctl_n | input | 1 | Requested chip-select level |
| fifo_rst | input | 1 | Flush of both FIFOs |
| tx_wr | input | 1 | Push into the transmit FIFO |
| tx_wdata | input | 32 | Word to push |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_rd | input | 1 | Pop from the receive FIFO |
| rx_rdata | output | 32 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| int_en | input | 10 | Event enable mask |
| int_clr | input | 10 | Write-1 clear of event flags |
| raw_sts | output | 10 | Event flags: bit 8 transmit end, bit 9 receive end |
| irq | output | 1 | Masked event request |
| busy | output | 1 | Burst in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| miso | input | 1 | Serial data in |

## Verification
The transmit-end event and a software clear of the same flag can land on one clock edge, and the outcome decides whether an event is silently lost. The bench holds the transmit-end clear bit at 1 for an entire transmit burst, so the setting cycle is certain to meet a clear. It then counts the cycles in which the flag reads 1: exactly one cycle proves that the set won and the clear took effect on the following edge, while zero would mean the event had been dropped.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } sbe_state_e;

  localparam int STS_W      = 10;
  localparam int TXEND_BIT  = 8;
  localparam int RXEND_BIT  = 9;
  localparam int GAP_MUL_SH = 2;   // gap code is multiplied by 4
  localparam int GAP_BASE   = 10;  // plus a fixed 10 cycles
endpackage

// File: rtl/sbe_fifo.sv
module sbe_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32   // power of two
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic         do_push, do_pop;

  assign empty   = (wptr_q == rptr_q);
  assign full    = (wptr_q == (rptr_q ^ {1'b1, {AW{1'b0}}}));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = mem[rptr_q[AW-1:0]];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
    end else begin
      if (do_push) wptr_d = wptr_q + 1'b1;
      if (do_pop)  rptr_d = rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q[AW-1:0]] <= wdata;
  end

  p_flush_empties_r14: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((wptr_q - rptr_q) <= (AW+1)'(DEPTH)));
endmodule

// File: rtl/sbe_shifter.sv
module sbe_shifter #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [W-1:0]         load_data,
  input  logic [$clog2(W)-1:0] msb_idx,
  input  logic                 shift_en,
  input  logic                 sample_en,
  input  logic                 miso,
  output logic                 mosi,
  output logic [W-1:0]         rx_word
);
  logic [W-1:0] tx_q, tx_d, rx_q, rx_d;

  assign mosi    = tx_q[msb_idx];
  assign rx_word = rx_q;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load) begin
      tx_d = load_data;
      rx_d = '0;
    end else begin
      if (shift_en)  tx_d = {tx_q[W-2:0], 1'b0};
      if (sample_en) rx_d = {rx_q[W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  p_no_load_mid_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(shift_en || sample_en));

  p_one_action_per_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_en && sample_en));
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import sbe_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 32,
  parameter int PRESC_W    = 8,
  parameter int GAP_W      = 6,
  parameter int LEN_HI_W   = 4,
  parameter int LEN_LO_W   = 16,
  parameter int RXCNT_W    = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_cpol,
  input  logic                      cfg_cpha,
  input  logic [PRESC_W-1:0]        cfg_prescale,
  input  logic [$clog2(DATA_W)-1:0] cfg_wlen,
  input  logic [GAP_W-1:0]          cfg_gap,
  input  logic                      cfg_tx_en,
  input  logic                      cfg_rx_en,
  input  logic [LEN_HI_W-1:0]       burst_len_hi,
  input  logic [LEN_LO_W-1:0]       burst_len_lo,
  input  logic                      go,
  input  logic [RXCNT_W-1:0]        rx_only_cnt,
  input  logic                      rx_only_start,
  input  logic                      cs_ctl_n,
  input  logic                      fifo_rst,
  input  logic                      tx_wr,
  input  logic [DATA_W-1:0]         tx_wdata,
  output logic                      tx_full,
  output logic                      tx_empty,
  input  logic                      rx_rd,
  output logic [DATA_W-1:0]         rx_rdata,
  output logic                      rx_empty,
  output logic                      rx_full,
  input  logic [STS_W-1:0]          int_en,
  input  logic [STS_W-1:0]          int_clr,
  output logic [STS_W-1:0]          raw_sts,
  output logic                      irq,
  output logic                      busy,
  output logic                      sck,
  output logic                      mosi,
  output logic                      cs_n,
  input  logic                      miso
);
  localparam int WLEN_W = $clog2(DATA_W);
  localparam int ECNT_W = WLEN_W + 1;
  localparam int LEN_W  = LEN_HI_W + LEN_LO_W;
  localparam int GCNT_W = GAP_W + 3;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  sbe_state_e         state_q, state_d;
  logic [PRESC_W-1:0] tmr_q, tmr_d;
  logic [ECNT_W-1:0]  ecnt_q, ecnt_d;
  logic [LEN_W-1:0]   words_q, words_d;
  logic [GCNT_W-1:0]  gap_q, gap_d, gap_len;
  logic               sckph_q, sckph_d, btx_q, btx_d, brx_q, brx_d;
  logic               push_q, pushlast_q, rxst_q, cs_q;
  logic [STS_W-1:0]   sts_q, sts_set;
  logic [WLEN_W-1:0]  msb_idx;
  logic [LEN_W-1:0]   burst_len;
  logic [DATA_W-1:0]  tx_rdata, rx_word;
  logic edge_ev, last_edge, word_end, sample_en, shift_en;
  logic launch_tx, launch_rx, abort, load, tx_pop, tx_end_set, rx_end_set;

  assign msb_idx   = cfg_wlen - 1'b1;            // code 0 wraps to 31 -> 32 bits
  assign burst_len = {burst_len_hi, burst_len_lo};
  assign gap_len   = GCNT_W'({cfg_gap, {GAP_MUL_SH{1'b0}}}) + GCNT_W'(GAP_BASE);

  assign busy      = (state_q != ST_IDLE);
  assign edge_ev   = (state_q == ST_SHIFT) && (tmr_q == cfg_prescale);
  assign last_edge = (ecnt_q == {msb_idx, 1'b1});
  assign word_end  = edge_ev && last_edge;
  assign sample_en = edge_ev && (ecnt_q[0] == cfg_cpha);
  assign shift_en  = edge_ev && (ecnt_q[0] != cfg_cpha) && (ecnt_q != '0);

  assign launch_tx = go && cfg_tx_en && (burst_len != '0);
  assign launch_rx = rx_only_start && !rxst_q && cfg_rx_en && !cfg_tx_en
                     && (rx_only_cnt != '0);
  assign abort     = busy && (!(cfg_tx_en || cfg_rx_en) || (!btx_q && !rx_only_start));
  assign load      = (state_q == ST_LOAD) && (!btx_q || !tx_empty) && !abort;
  assign tx_pop    = load && btx_q;

  assign tx_end_set = tx_pop && (words_q == LEN_W'(1));
  assign rx_end_set = push_q && pushlast_q;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    ecnt_d  = ecnt_q;
    words_d = words_q;
    gap_d   = gap_q;
    sckph_d = sckph_q;
    btx_d   = btx_q;
    brx_d   = brx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (launch_tx) begin
          state_d = ST_LOAD;
          words_d = burst_len;
          btx_d   = 1'b1;
          brx_d   = cfg_rx_en;
        end else if (launch_rx) begin
          state_d = ST_LOAD;
          words_d = LEN_W'(rx_only_cnt);
          btx_d   = 1'b0;
          brx_d   = 1'b1;
        end
      end
      ST_LOAD: begin
        if (load) begin
          state_d = ST_SHIFT;
          tmr_d   = '0;
          ecnt_d  = '0;
        end
      end
      ST_SHIFT: begin
        if (edge_ev) begin
          tmr_d   = '0;
          sckph_d = ~sckph_q;
          ecnt_d  = ecnt_q + 1'b1;
          if (last_edge) begin
            words_d = words_q - 1'b1;
            if (words_q == LEN_W'(1)) begin
              state_d = ST_IDLE;
            end else begin
              state_d = ST_GAP;
              gap_d   = '0;
            end
          end
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_q == gap_len - 1'b1) state_d = ST_LOAD;
        else                         gap_d   = gap_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort) begin
      state_d = ST_IDLE;
      sckph_d = 1'b0;
    end
  end

  always_comb begin
    sts_set            = '0;
    sts_set[TXEND_BIT] = tx_end_set;
    sts_set[RXEND_BIT] = rx_end_set;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q    <= ST_IDLE;
      tmr_q      <= '0;
      ecnt_q     <= '0;
      words_q    <= '0;
      gap_q      <= '0;
      sckph_q    <= 1'b0;
      btx_q      <= 1'b0;
      brx_q      <= 1'b0;
      push_q     <= 1'b0;
      pushlast_q <= 1'b0;
      rxst_q     <= 1'b0;
      cs_q       <= 1'b1;
      sts_q      <= '0;
    end else begin
      state_q    <= state_d;
      tmr_q      <= tmr_d;
      ecnt_q     <= ecnt_d;
      words_q    <= words_d;
      gap_q      <= gap_d;
      sckph_q    <= sckph_d;
      btx_q      <= btx_d;
      brx_q      <= brx_d;
      push_q     <= word_end && brx_q && !abort;
      pushlast_q <= (words_q == LEN_W'(1));
      rxst_q     <= rx_only_start;
      cs_q       <= cs_ctl_n;
      sts_q      <= sts_set | (sts_q & ~int_clr);   // set wins over clear
    end
  end

  assign sck     = sckph_q ^ cfg_cpol;
  assign cs_n    = cs_q;
  assign raw_sts = sts_q;
  assign irq     = |(sts_q & int_en);

  sbe_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_i_n), .flush(fifo_rst),
    .push(tx_wr), .wdata(tx_wdata), .pop(tx_pop),
    .rdata(tx_rdata), .empty(tx_empty), .full(tx_full));

  sbe_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_i_n), .flush(fifo_rst),
    .push(push_q), .wdata(rx_word), .pop(rx_rd),
    .rdata(rx_rdata), .empty(rx_empty), .full(rx_full));

  sbe_shifter #(.W(DATA_W)) u_shf (
    .clk(clk), .rst_n(rst_i_n), .load(load),
    .load_data(btx_q ? tx_rdata : '0), .msb_idx(msb_idx),
    .shift_en(shift_en), .sample_en(sample_en), .miso(miso),
    .mosi(mosi), .rx_word(rx_word));

  p_txend_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(raw_sts[TXEND_BIT]) |-> busy);

  p_clear_takes_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (int_clr[RXEND_BIT] && !rx_end_set) |=> !raw_sts[RXEND_BIT]);

  p_gap_quiet_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_GAP) |-> ((gap_q < gap_len) && (sck == cfg_cpol)));

  p_modes_off_idle_r12: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!cfg_tx_en && !cfg_rx_en) |=> !busy);

  p_rxonly_quiet_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && !btx_q) |-> !mosi);
endmodule

// File: tb/sim_spi_burst_engine.sv
module sim_spi_burst_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cpol = 0, cfg_cpha = 0, cfg_tx_en = 0, cfg_rx_en = 0;
  logic [7:0]  cfg_prescale = 0;
  logic [4:0]  cfg_wlen = 5'd8;
  logic [5:0]  cfg_gap = 0;
  logic [3:0]  burst_len_hi = 0;
  logic [15:0] burst_len_lo = 0;
  logic        go = 0, rx_only_start = 0, cs_ctl_n = 1, fifo_rst = 0;
  logic [8:0]  rx_only_cnt = 0;
  logic        tx_wr = 0, rx_rd = 0;
  logic [31:0] tx_wdata = 0;
  logic [9:0]  int_en = 0, int_clr = 0;
  logic        tx_full, tx_empty, rx_empty, rx_full, irq, busy, sck, mosi, cs_n, miso;
  logic [31:0] rx_rdata;
  logic [9:0]  raw_sts;

  int errs = 0, checks = 0, cyc = 0;

  logic        loop_sel = 1, slv_miso = 0, slv_on = 0;
  logic [15:0] pat = 0;
  int          sidx = 0;
  assign miso = loop_sel ? mosi : slv_miso;

  spi_burst_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_prescale(cfg_prescale), .cfg_wlen(cfg_wlen), .cfg_gap(cfg_gap),
    .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en), .burst_len_hi(burst_len_hi),
    .burst_len_lo(burst_len_lo), .go(go), .rx_only_cnt(rx_only_cnt),
    .rx_only_start(rx_only_start), .cs_ctl_n(cs_ctl_n), .fifo_rst(fifo_rst),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_empty(rx_empty), .rx_full(rx_full),
    .int_en(int_en), .int_clr(int_clr), .raw_sts(raw_sts), .irq(irq),
    .busy(busy), .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(miso));

  always #5 clk = ~clk;   // 100 MHz

  // {cpol, cpha, prescale[2:0], wlen[4:0], data[31:0]}
  localparam logic [41:0] VEC [6] = '{
    {1'b0, 1'b0, 3'd1, 5'd8,  32'h0000_00A5},
    {1'b0, 1'b1, 3'd2, 5'd16, 32'h1234_BEEF},
    {1'b1, 1'b0, 3'd0, 5'd0,  32'hA5C3_0F81},
    {1'b1, 1'b1, 3'd3, 5'd1,  32'hFFFF_FFFF},
    {1'b0, 1'b1, 3'd0, 5'd31, 32'hDEAD_BEEF},
    {1'b1, 1'b0, 3'd2, 5'd5,  32'h0000_0013}
  };

  // monitors, all sampled on the falling clock edge
  int   et [64];
  int   ne = 0, n8 = 0;
  logic mon_on = 0, cap_on = 0, cnt8_on = 0, mosi_watch = 0, mosi_seen = 0;
  logic sck_prev = 0, raw8_prev = 0, busy_at_txend = 0;
  logic [31:0] mcap = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_on && (sck !== sck_prev) && ne < 64) begin
      et[ne] = cyc;
      ne++;
    end
    sck_prev = sck;
    if (cnt8_on && raw_sts[8]) n8++;
    if (raw_sts[8] && !raw8_prev) busy_at_txend = busy;
    raw8_prev = raw_sts[8];
    if (mosi_watch && mosi) mosi_seen = 1'b1;
  end

  always @(posedge sck) if (cap_on) mcap = {mcap[30:0], mosi};

  always @(negedge sck) begin
    if (slv_on && sidx < 15) begin
      sidx++;
      slv_miso = pat[15 - sidx];
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      report();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx(input logic [31:0] d);
    tx_wr = 1'b1; tx_wdata = d; tick(1); tx_wr = 1'b0;
  endtask

  task automatic pop_rx();
    rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
  endtask

  task automatic pulse_go();
    go = 1'b1; tick(1); go = 1'b0;
  endtask

  task automatic clear_flags();
    int_clr = 10'h300; tick(1); int_clr = 10'h000;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      if (!busy) break;
      tick(1);
    end
  endtask

  initial begin
    // reset state
    tick(3); rst_n = 1'b1; tick(4);
    chk("R1 cs_n", cs_n, 1); chk("R1 sck", sck, 0); chk("R1 busy", busy, 0);
    chk("R1 raw_sts", raw_sts, 0); chk("R1 irq", irq, 0);
    chk("R1 rx_empty", rx_empty, 1); chk("R1 tx_empty", tx_empty, 1);

    // chip select
    cs_ctl_n = 1'b0; tick(1);
    chk("R13 cs_n low", cs_n, 0);

    // vector table: single-word full-duplex loopback
    loop_sel = 1'b1;
    for (int k = 0; k < 6; k++) begin
      automatic logic [41:0] v = VEC[k];
      automatic logic [63:0] m = (v[36:32] == 5'd0) ? 64'hFFFF_FFFF
                                 : ((64'd1 << v[36:32]) - 64'd1);
      cfg_cpol = v[41]; cfg_cpha = v[40]; cfg_prescale = {5'd0, v[39:37]};
      cfg_wlen = v[36:32]; cfg_gap = 6'd0;
      cfg_tx_en = 1'b1; cfg_rx_en = 1'b1; burst_len_lo = 16'd1;
      push_tx(v[31:0]);
      pulse_go();
      wait_idle();
      tick(2);
      chk("R2 sck idle level", sck, v[41]);
      chk("R6 word stored", rx_empty, 0);
      chk("R3 R4 loopback word", rx_rdata, v[31:0] & m[31:0]);
      chk("R9 rx end", raw_sts[9], 1);
      chk("R8 tx end", raw_sts[8], 1);
      pop_rx();
      clear_flags();
    end

    // transmit-only, two words: timing, bit order, flags
    cfg_cpol = 0; cfg_cpha = 0; cfg_prescale = 8'd1; cfg_wlen = 5'd8; cfg_gap = 6'd1;
    cfg_tx_en = 1; cfg_rx_en = 0; burst_len_lo = 16'd2;
    push_tx(32'hA5); push_tx(32'h3C);
    tick(1);
    ne = 0; mon_on = 1; cap_on = 1; mcap = 0; busy_at_txend = 0;
    pulse_go();
    wait_idle();
    tick(2);
    mon_on = 0; cap_on = 0;
    chk("R6 edge count", ne, 32);
    chk("R2 half period", et[1] - et[0], 2);
    chk("R5 word spacing", et[16] - et[15], 4 * 1 + 12 + 1);
    chk("R3 msb first", mcap[15:0], 16'hA53C);
    chk("R6 tx-only stores nothing", rx_empty, 1);
    chk("R9 no rx end", raw_sts[9], 0);
    chk("R8 tx end set", raw_sts[8], 1);
    chk("R8 busy at tx end", busy_at_txend, 1);

    // interrupt mask and clear
    int_en = 10'h100; tick(1);
    chk("R11 irq enabled", irq, 1);
    int_en = 10'h200; tick(1);
    chk("R11 irq masked", irq, 0);
    int_en = 10'h100;
    int_clr = 10'h100; tick(1); int_clr = 0;
    chk("R10 cleared", raw_sts[8], 0);
    chk("R11 irq after clear", irq, 0);
    int_en = 0;

    // set and clear in the same cycle
    cfg_gap = 6'd0; burst_len_lo = 16'd1;
    push_tx(32'h5A);
    int_clr = 10'h100; n8 = 0; cnt8_on = 1;
    pulse_go();
    wait_idle();
    tick(2);
    cnt8_on = 0; int_clr = 0;
    chk("R10 set wins collision", n8, 1);

    // receive-only, two frames from a bench slave
    cfg_tx_en = 0; cfg_rx_en = 1; cfg_prescale = 8'd0; cfg_wlen = 5'd8;
    rx_only_cnt = 9'd2;
    tick(2);
    loop_sel = 0; pat = 16'hC35A; sidx = 0; slv_miso = pat[15]; slv_on = 1;
    mosi_seen = 0; mosi_watch = 1;
    rx_only_start = 1; tick(1);
    chk("R7 started", busy, 1);
    wait_idle();
    tick(2);
    mosi_watch = 0; slv_on = 0;
    chk("R7 first word", rx_rdata, 32'hC3); pop_rx();
    chk("R7 second word", rx_rdata, 32'h5A); pop_rx();
    chk("R7 mosi held low", mosi_seen, 0);
    chk("R9 rx end", raw_sts[9], 1);
    rx_only_start = 0; tick(1);
    clear_flags();

    // receive-only stopped by dropping the start level
    cfg_prescale = 8'd3; rx_only_cnt = 9'd5;
    rx_only_start = 1; tick(10);
    chk("R7 running", busy, 1);
    rx_only_start = 0; tick(2);
    chk("R7 stopped", busy, 0);
    chk("R2 sck idle after stop", sck, 0);

    // no mode bits: go ignored, then abort a running burst
    cfg_tx_en = 0; cfg_rx_en = 0; burst_len_lo = 16'd1;
    push_tx(32'h1234_5678);
    pulse_go(); tick(3);
    chk("R12 go ignored", busy, 0);
    chk("R12 word kept", tx_empty, 0);
    cfg_tx_en = 1; cfg_prescale = 8'd7; cfg_wlen = 5'd0;
    pulse_go(); tick(6);
    chk("R12 running", busy, 1);
    cfg_tx_en = 0; tick(1);
    chk("R12 aborted", busy, 0);
    chk("R12 sck idle", sck, 0);

    // flush of both queues
    loop_sel = 1; cfg_prescale = 8'd0; cfg_wlen = 5'd8;
    push_tx(32'h11); push_tx(32'h22);
    cfg_tx_en = 1; cfg_rx_en = 1; burst_len_lo = 16'd1;
    pulse_go(); wait_idle(); tick(2);
    cfg_tx_en = 0; cfg_rx_en = 0;
    chk("R14 rx filled", rx_empty, 0);
    chk("R14 tx filled", tx_empty, 0);
    fifo_rst = 1; tick(1); fifo_rst = 0; tick(1);
    chk("R14 tx flushed", tx_empty, 1);
    chk("R14 rx flushed", rx_empty, 1);

    cs_ctl_n = 1; tick(1);
    chk("R13 cs_n high", cs_n, 1);

    report();
  end
endmodule